// File: doc/BRIEF.md
# Split-Section Falling-Edge Ripple Counter

This block is a small binary counter split into two halves. The low half is a single toggle stage with its own falling-edge clock, so it divides that clock by two. The high half is a chain of toggle stages, three by default. The first stage of the chain is clocked by a second, independent falling-edge input, and each later stage is clocked by the falling edge of the stage before it. Because the stages ripple, the outputs settle one after another rather than together. Decoded combinations of the outputs can therefore glitch and must not be used as clocks.

Two active-high clear inputs are ANDed together. While both are high, every stage is forced low at once, and both clocks are ignored for as long as the clear is held. A mode parameter either keeps the halves apart, or feeds the low stage's output into the high half internally to form one plain binary counter. The same full count can also be built in split mode by wiring output bit 0 back to the high clock input outside the block.

Top module: `rc_split_counter`

## Requirements
- R1: Output bit 0 inverts on every falling edge of `clk_lo_i`. A rising edge of `clk_lo_i` leaves it unchanged.
- R2: In split mode, output bits [3:1] read as an unsigned value with bit 1 as the LSB. That value increases by one, modulo 8, on every falling edge of `clk_hi_i`.
- R3: In split mode, `clk_hi_i` has no effect on bit 0, and `clk_lo_i` has no effect on bits [3:1].
- R4: In chained mode, or in split mode with bit 0 wired to `clk_hi_i` outside the block, `q_o` read as unsigned with bit 0 as the LSB increases by one on each falling edge of `clk_lo_i`. After 15 it wraps to 0.
- R5: In chained mode, `clk_hi_i` has no effect on any output.
- R6: While `clr_a_i` and `clr_b_i` are both high, all outputs are 0. This takes effect without any clock edge.
- R7: While the clear is held, falling edges on either clock leave all outputs at 0.
- R8: With only one of the two clear inputs high, the counter counts exactly as it does with neither high.
- R9: After the clear is released, the first falling edge of `clk_lo_i` sets the count to 1. In split mode, the first falling edge of `clk_hi_i` sets bits [3:1] to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lo_i | input | 1 | Falling-edge clock of the low toggle stage |
| clk_hi_i | input | 1 | Falling-edge clock of the high chain (ignored in chained mode) |
| clr_a_i | input | 1 | Clear input A, active high, ANDed with B |
| clr_b_i | input | 1 | Clear input B, active high, ANDed with A |
| q_o | output | HI_STAGES+1 | Stage outputs, bit 0 is the low stage |

## Verification
The bench builds three copies, each with the default three-stage high chain. One copy is in split mode with both clocks driven on their own. One is in chained mode. The third is in split mode with bit 0 looped back to its high clock input. Running the low clock through more than two full cycles of sixteen walks both the internal and the external chaining through every count and across the wrap. Driving the high clock alone then shows that the high section wraps at eight, and that each section ignores the clock it does not own. Edges applied with one clear input high, and then with both held, separate the AND gating from plain clearing.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic {
    MODE_SPLIT   = 1'b0,
    MODE_CHAINED = 1'b1
  } rc_mode_e;

  localparam int unsigned RC_HI_STAGES_DEF = 3;
endpackage

// File: rtl/rc_toggle_stage.sv
module rc_toggle_stage (
  input  logic clk_ni,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(negedge clk_ni or posedge clr_i) begin
    if (clr_i) q_o <= 1'b0;
    else       q_o <= ~q_o;
  end
endmodule

// File: rtl/rc_ripple_chain.sv
module rc_ripple_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk_ni,
  input  logic              clr_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES:0] tick;

  assign tick[0] = clk_ni;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    rc_toggle_stage u_stage (
      .clk_ni(tick[k]),
      .clr_i (clr_i),
      .q_o   (q_o[k])
    );
    // each later stage fires on the fall of the one before
    assign tick[k+1] = q_o[k];
  end
endmodule

// File: rtl/rc_split_counter.sv
module rc_split_counter
  import rc_pkg::*;
#(
  parameter int unsigned HI_STAGES = RC_HI_STAGES_DEF,
  parameter rc_mode_e    MODE      = MODE_SPLIT
) (
  input  logic               clk_lo_i,
  input  logic               clk_hi_i,
  input  logic               clr_a_i,
  input  logic               clr_b_i,
  output logic [HI_STAGES:0] q_o
);
  logic clr;
  logic q_lo;
  logic hi_clk;
  logic [HI_STAGES-1:0] q_hi;

  assign clr = clr_a_i & clr_b_i;

  rc_toggle_stage u_lo (
    .clk_ni(clk_lo_i),
    .clr_i (clr),
    .q_o   (q_lo)
  );

  if (MODE == MODE_CHAINED) begin : g_chained
    logic unused_clk_hi;
    assign unused_clk_hi = clk_hi_i;
    assign hi_clk = q_lo;
  end else begin : g_split
    assign hi_clk = clk_hi_i;
  end

  rc_ripple_chain #(.STAGES(HI_STAGES)) u_hi (
    .clk_ni(hi_clk),
    .clr_i (clr),
    .q_o   (q_hi)
  );

  assign q_o = {q_hi, q_lo};
endmodule

// File: rtl/rc_split_counter_chk.sv
module rc_split_counter_chk
  import rc_pkg::*;
#(
  parameter int unsigned HI_STAGES = RC_HI_STAGES_DEF,
  parameter rc_mode_e    MODE      = MODE_SPLIT
) (
  input logic               clk_lo_i,
  input logic               clk_hi_i,
  input logic               clr_a_i,
  input logic               clr_b_i,
  input logic [HI_STAGES:0] q_o
);
  localparam int unsigned N = HI_STAGES + 1;
  logic clr;
  assign clr = clr_a_i & clr_b_i;

  p_lo_toggle_r1: assert property (@(negedge clk_lo_i) disable iff (clr)
    1'b1 |=> q_o[0] != $past(q_o[0]));

  p_clear_holds_r6: assert property (@(negedge clk_lo_i)
    clr |-> q_o == '0);

  if (MODE == MODE_CHAINED) begin : g_chained
    p_full_count_r4: assert property (@(negedge clk_lo_i) disable iff (clr)
      1'b1 |=> q_o == N'($past(q_o) + 1'b1));
  end else begin : g_split
    p_hi_count_r2: assert property (@(negedge clk_hi_i) disable iff (clr)
      1'b1 |=> q_o[HI_STAGES:1] == HI_STAGES'($past(q_o[HI_STAGES:1]) + 1'b1));
    p_clear_hi_r7: assert property (@(negedge clk_hi_i)
      clr |-> q_o == '0);
  end
endmodule

bind rc_split_counter rc_split_counter_chk #(
  .HI_STAGES(HI_STAGES),
  .MODE     (MODE)
) u_chk (
  .clk_lo_i(clk_lo_i),
  .clk_hi_i(clk_hi_i),
  .clr_a_i (clr_a_i),
  .clr_b_i (clr_b_i),
  .q_o     (q_o)
);

// File: tb/sim_rc_split_counter.sv
module sim_rc_split_counter;
  import rc_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk_lo = 1'b0, clk_hi = 1'b0, clr_a = 1'b1, clr_b = 1'b1;
  logic [3:0] q0, q1, q2;
  int n_cmp = 0, n_bad = 0;

  // expected state
  logic       m_lo = 1'b0;
  logic [2:0] m_hi = '0;
  logic [3:0] m_full = '0;

  rc_split_counter #(.HI_STAGES(3), .MODE(MODE_SPLIT)) u0 (
    .clk_lo_i(clk_lo), .clk_hi_i(clk_hi), .clr_a_i(clr_a), .clr_b_i(clr_b), .q_o(q0));
  rc_split_counter #(.HI_STAGES(3), .MODE(MODE_CHAINED)) u1 (
    .clk_lo_i(clk_lo), .clk_hi_i(clk_hi), .clr_a_i(clr_a), .clr_b_i(clr_b), .q_o(q1));
  rc_split_counter #(.HI_STAGES(3), .MODE(MODE_SPLIT)) u2 (
    .clk_lo_i(clk_lo), .clk_hi_i(q2[0]), .clr_a_i(clr_a), .clr_b_i(clr_b), .q_o(q2));

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulse_lo();
    clk_lo = 1'b1; #(CLK_PERIOD/2);
    clk_lo = 1'b0; #(CLK_PERIOD/2);
    if (!(clr_a && clr_b)) begin
      m_lo   = ~m_lo;
      m_full = m_full + 4'd1;
    end
  endtask

  task automatic pulse_hi();
    clk_hi = 1'b1; #(CLK_PERIOD/2);
    clk_hi = 1'b0; #(CLK_PERIOD/2);
    if (!(clr_a && clr_b)) m_hi = m_hi + 3'd1;
  endtask

  task automatic check_all(input string tag);
    check({tag, " u0"}, q0, {m_hi, m_lo});
    check({tag, " u1"}, q1, m_full);
    check({tag, " u2"}, q2, m_full);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD);
    check_all("R6 reset");
    clr_a = 1'b0; clr_b = 1'b0;
    #(CLK_PERIOD);
    check_all("R6 release idle");

    // R1 rising edge alone changes nothing
    clk_lo = 1'b1; #(CLK_PERIOD/2);
    check_all("R1 rise only");
    clk_lo = 1'b0; #(CLK_PERIOD/2);
    m_lo = ~m_lo; m_full = m_full + 4'd1;
    check_all("R9 first fall after clear");

    // R1 R4 R3: sweep low clock across two wraps
    for (int i = 0; i < 39; i++) begin
      pulse_lo();
      check_all("R1 R4 R3 lo sweep");
    end

    // R2 R3 R5: high clock alone
    for (int i = 0; i < 20; i++) begin
      pulse_hi();
      check_all("R2 R3 R5 hi sweep");
    end

    // R8: one clear input at a time
    clr_a = 1'b1;
    for (int i = 0; i < 3; i++) begin
      pulse_lo(); pulse_hi();
      check_all("R8 clr_a only");
    end
    clr_a = 1'b0; clr_b = 1'b1;
    for (int i = 0; i < 3; i++) begin
      pulse_lo(); pulse_hi();
      check_all("R8 clr_b only");
    end
    if (m_full[0]) pulse_lo();
    check_all("R8 even count");

    // R6 asynchronous, R7 held
    clr_a = 1'b1;
    m_lo = 1'b0; m_hi = '0; m_full = '0;
    #1;
    check_all("R6 async clear");
    for (int i = 0; i < 3; i++) begin
      pulse_lo(); pulse_hi();
      check_all("R7 clear held");
    end
    clr_a = 1'b0; clr_b = 1'b0;
    #(CLK_PERIOD);
    pulse_lo();
    check_all("R9 lo after release");
    pulse_hi();
    check_all("R9 hi after release");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule